// File: doc/BRIEF.md
# Out-of-Order Issue Queue with Tag Wakeup

This block holds renamed instructions between rename and the execution units. Each held instruction keeps its opcode, its destination tag and two source tags. Each source tag has its own ready flag. An instruction leaves as soon as both of its sources are ready, whatever its place in program order. The cycle-level choice among ready instructions favours the oldest. Up to three instructions go out per cycle, one to each ALU port. Every issue port carries the source tags, so the ALU can read its operands from the physical register file.

Completion ports broadcast destination tags into the queue. Every held source whose tag matches a broadcast becomes ready. An instruction inserted in the same cycle as a matching broadcast also picks up that broadcast. Commit needs no action here, because waiting sources keep the tags they were given at rename.

Program age comes from a wrapping sequence number that rename attaches to each instruction. The same numbers drive the flush input. A flush can discard either every entry or only the entries younger than a given sequence number.

Top module: `issue_queue`

## Requirements
- R1: After reset the queue is empty: `ins_ready` is 1 and every `iss_valid` bit is 0.
- R2: `ins_ready` is 0 while all DEPTH (8) entries hold instructions, and also in any cycle where `flush_valid` is 1. An insert offered while `ins_ready` is 0 is dropped and changes nothing.
- R3: An accepted insert stores its opcode, destination tag, source tags and the two source ready flags `ins_src1_rdy` and `ins_src2_rdy`. A source inserted with its flag at 0 stays not ready until a broadcast wakes it.
- R4: A source is woken by a broadcast port p when `bc_valid[p]` is 1 and `bc_tag[p]` equals the source tag. Any of the three ports can wake any held source, and one broadcast can wake several sources.
- R5: A broadcast in the same cycle as an insert wakes the inserted sources whose tags match it.
- R6: An entry with both sources ready is offered for issue from the cycle after its last source became ready. An entry inserted with both flags at 1 is offered in the cycle after the insert.
- R7: In each cycle at most ISSUE_W (3) entries issue. They are the oldest ready entries, ranked by sequence number with wrap-aware comparison. Port 0 carries the oldest, port 1 the next oldest, and so on, and a port without a candidate shows `iss_valid` at 0.
- R8: An entry shown on an issue port is removed at the next clock edge and is never issued twice.
- R9: `flush_valid` with `flush_all` at 1 empties the queue at the next edge.
- R10: `flush_valid` with `flush_all` at 0 removes exactly the entries whose sequence number is younger than `flush_seq`. Younger means that (seq − flush_seq) mod 2^SEQ_W is nonzero with its top bit at 0. The entry carrying `flush_seq` itself and all older entries stay.
- R11: Each issue port k outputs the opcode, destination tag and both source tags of the entry it carries, from the same entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request from rename |
| ins_ready | output | 1 | Queue can accept an insert this cycle |
| ins_op | input | OP_W | Opcode of inserted instruction |
| ins_dst | input | TAG_W | Destination physical tag |
| ins_src1 | input | TAG_W | First source tag |
| ins_src1_rdy | input | 1 | First source already available |
| ins_src2 | input | TAG_W | Second source tag |
| ins_src2_rdy | input | 1 | Second source already available |
| ins_seq | input | SEQ_W | Program-order sequence number |
| bc_valid | input | BCAST_W | Broadcast port valid bits |
| bc_tag | input | BCAST_W x TAG_W | Broadcast destination tags |
| iss_valid | output | ISSUE_W | Issue port valid bits |
| iss_op | output | ISSUE_W x OP_W | Issued opcode per port |
| iss_dst | output | ISSUE_W x TAG_W | Issued destination tag per port |
| iss_src1 | output | ISSUE_W x TAG_W | Issued first source tag per port |
| iss_src2 | output | ISSUE_W x TAG_W | Issued second source tag per port |
| flush_valid | input | 1 | Flush request |
| flush_all | input | 1 | Flush every entry instead of only younger ones |
| flush_seq | input | SEQ_W | Entries younger than this are flushed |

## Verification
The bench uses the default build: eight entries, three issue ports, three broadcast ports and 6-bit tags and sequence numbers. With these values the queue fills within a few inserts, so the full condition and the three-way ranking are reached often. Random sequence numbers run through thousands of inserts, so they wrap many times and the wrap-aware age and flush comparisons are exercised across the wrap point. Random source tags are drawn from a narrow range of sixteen. This keeps several entries waking on one broadcast and several matching ports in one cycle.

// File: rtl/iq_pkg.sv
package iq_pkg;
    parameter int OP_W  = 6;
    parameter int TAG_W = 6;
    parameter int SEQ_W = 6;

    typedef logic [OP_W-1:0]  op_t;
    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [SEQ_W-1:0] seq_t;

    typedef struct packed {
        logic valid;
        op_t  op;
        tag_t dst;
        tag_t src1;
        logic rdy1;
        tag_t src2;
        logic rdy2;
        seq_t seq;
    } iq_entry_t;

    // a is older than b when the wrapped difference a-b is negative
    function automatic logic seq_older(seq_t a, seq_t b);
        seq_t diff;
        diff = a - b;
        return diff[SEQ_W-1];
    endfunction
endpackage

// File: rtl/iq_wakeup.sv
module iq_wakeup
    import iq_pkg::*;
#(
    parameter int BCAST_W = 3
) (
    input  tag_t                     tag,
    input  logic [BCAST_W-1:0]       bc_valid,
    input  tag_t [BCAST_W-1:0]       bc_tag,
    output logic                     hit
);
    always_comb begin
        hit = 1'b0;
        for (int p = 0; p < BCAST_W; p++) begin
            if (bc_valid[p] && (bc_tag[p] == tag)) hit = 1'b1;
        end
    end
endmodule

// File: rtl/iq_select.sv
module iq_select
    import iq_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int ISSUE_W = 3,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0]              req,
    input  seq_t [DEPTH-1:0]              seq,
    output logic [ISSUE_W-1:0]            gnt_valid,
    output logic [ISSUE_W-1:0][IDX_W-1:0] gnt_idx,
    output logic [DEPTH-1:0]              gnt_mask
);
    logic [DEPTH-1:0][CNT_W-1:0] rank;

    // rank of a requester = number of older requesters
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            rank[i] = '0;
            for (int j = 0; j < DEPTH; j++) begin
                if (j != i && req[j] && seq_older(seq[j], seq[i]))
                    rank[i] = rank[i] + CNT_W'(1);
            end
            gnt_mask[i] = req[i] && (rank[i] < CNT_W'(ISSUE_W));
        end
    end

    always_comb begin
        for (int k = 0; k < ISSUE_W; k++) begin
            gnt_valid[k] = 1'b0;
            gnt_idx[k]   = '0;
            for (int i = 0; i < DEPTH; i++) begin
                if (req[i] && (rank[i] == CNT_W'(k))) begin
                    gnt_valid[k] = 1'b1;
                    gnt_idx[k]   = IDX_W'(i);
                end
            end
        end
    end
endmodule

// File: rtl/issue_queue.sv
module issue_queue
    import iq_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int ISSUE_W = 3,
    parameter int BCAST_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ins_valid,
    output logic                       ins_ready,
    input  logic [OP_W-1:0]            ins_op,
    input  logic [TAG_W-1:0]           ins_dst,
    input  logic [TAG_W-1:0]           ins_src1,
    input  logic                       ins_src1_rdy,
    input  logic [TAG_W-1:0]           ins_src2,
    input  logic                       ins_src2_rdy,
    input  logic [SEQ_W-1:0]           ins_seq,
    input  logic [BCAST_W-1:0]         bc_valid,
    input  logic [BCAST_W-1:0][TAG_W-1:0] bc_tag,
    output logic [ISSUE_W-1:0]         iss_valid,
    output logic [ISSUE_W-1:0][OP_W-1:0]  iss_op,
    output logic [ISSUE_W-1:0][TAG_W-1:0] iss_dst,
    output logic [ISSUE_W-1:0][TAG_W-1:0] iss_src1,
    output logic [ISSUE_W-1:0][TAG_W-1:0] iss_src2,
    input  logic                       flush_valid,
    input  logic                       flush_all,
    input  logic [SEQ_W-1:0]           flush_seq
);
    localparam int IDX_W = $clog2(DEPTH);

    typedef struct packed {
        iq_entry_t [DEPTH-1:0] ent;
    } state_t;

    state_t st_d, st_q;

    logic [DEPTH-1:0]              valid_vec, req_vec, hit1, hit2, gnt_mask;
    seq_t [DEPTH-1:0]              seq_vec;
    logic [ISSUE_W-1:0]            gnt_valid;
    logic [ISSUE_W-1:0][IDX_W-1:0] gnt_idx;
    logic                          ins_hit1, ins_hit2, full;
    logic [IDX_W-1:0]              free_idx;

    // per-entry wakeup comparators
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        assign valid_vec[i] = st_q.ent[i].valid;
        assign seq_vec[i]   = st_q.ent[i].seq;
        assign req_vec[i]   = st_q.ent[i].valid && st_q.ent[i].rdy1 && st_q.ent[i].rdy2;

        iq_wakeup #(.BCAST_W(BCAST_W)) u_wk1 (
            .tag(st_q.ent[i].src1), .bc_valid(bc_valid), .bc_tag(bc_tag), .hit(hit1[i]));
        iq_wakeup #(.BCAST_W(BCAST_W)) u_wk2 (
            .tag(st_q.ent[i].src2), .bc_valid(bc_valid), .bc_tag(bc_tag), .hit(hit2[i]));

        // R4
        wake_src1_chk: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.ent[i].valid && hit1[i] && !gnt_mask[i] && !flush_valid |=> st_q.ent[i].rdy1);
        // R4
        wake_src2_chk: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.ent[i].valid && hit2[i] && !gnt_mask[i] && !flush_valid |=> st_q.ent[i].rdy2);
        // R8
        issue_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_mask[i] |=> !st_q.ent[i].valid);
    end

    // same-cycle wakeup for the incoming instruction
    iq_wakeup #(.BCAST_W(BCAST_W)) u_wk_ins1 (
        .tag(ins_src1), .bc_valid(bc_valid), .bc_tag(bc_tag), .hit(ins_hit1));
    iq_wakeup #(.BCAST_W(BCAST_W)) u_wk_ins2 (
        .tag(ins_src2), .bc_valid(bc_valid), .bc_tag(bc_tag), .hit(ins_hit2));

    iq_select #(.DEPTH(DEPTH), .ISSUE_W(ISSUE_W)) u_sel (
        .req(req_vec), .seq(seq_vec),
        .gnt_valid(gnt_valid), .gnt_idx(gnt_idx), .gnt_mask(gnt_mask));

    // lowest free slot
    always_comb begin
        full     = &valid_vec;
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!valid_vec[i]) free_idx = IDX_W'(i);
        end
    end

    assign ins_ready = !full && !flush_valid;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (st_q.ent[i].valid) begin
                st_d.ent[i].rdy1 = st_q.ent[i].rdy1 | hit1[i];
                st_d.ent[i].rdy2 = st_q.ent[i].rdy2 | hit2[i];
            end
            if (gnt_mask[i]) st_d.ent[i].valid = 1'b0;
        end
        if (ins_valid && ins_ready) begin
            st_d.ent[free_idx].valid = 1'b1;
            st_d.ent[free_idx].op    = ins_op;
            st_d.ent[free_idx].dst   = ins_dst;
            st_d.ent[free_idx].src1  = ins_src1;
            st_d.ent[free_idx].rdy1  = ins_src1_rdy | ins_hit1;
            st_d.ent[free_idx].src2  = ins_src2;
            st_d.ent[free_idx].rdy2  = ins_src2_rdy | ins_hit2;
            st_d.ent[free_idx].seq   = ins_seq;
        end
        if (flush_valid) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (flush_all || seq_older(flush_seq, st_q.ent[i].seq))
                    st_d.ent[i].valid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        for (int k = 0; k < ISSUE_W; k++) begin
            iss_valid[k] = gnt_valid[k];
            iss_op[k]    = st_q.ent[gnt_idx[k]].op;
            iss_dst[k]   = st_q.ent[gnt_idx[k]].dst;
            iss_src1[k]  = st_q.ent[gnt_idx[k]].src1;
            iss_src2[k]  = st_q.ent[gnt_idx[k]].src2;
        end
    end

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && !ins_ready && !flush_valid |=> $countones(valid_vec) <= $past($countones(valid_vec)));
    // R9
    flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid && flush_all |=> valid_vec == '0);
    // R7
    issue_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gnt_mask) <= ISSUE_W);
    // R7
    issue_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid[0] |-> st_q.ent[gnt_idx[0]].valid && st_q.ent[gnt_idx[0]].rdy1 && st_q.ent[gnt_idx[0]].rdy2);
endmodule

// File: tb/issue_queue_tb_top.sv
`timescale 1ns/1ps
module issue_queue_tb_top;
    localparam int D = 8, IW = 3, BW = 3;

    logic clk = 0, rst_n = 0;
    always #10 clk = ~clk;

    logic ins_valid, ins_ready, ins_src1_rdy, ins_src2_rdy;
    logic [5:0] ins_op, ins_dst, ins_src1, ins_src2, ins_seq, flush_seq;
    logic [BW-1:0] bc_valid;
    logic [BW-1:0][5:0] bc_tag;
    logic [IW-1:0] iss_valid;
    logic [IW-1:0][5:0] iss_op, iss_dst, iss_src1, iss_src2;
    logic flush_valid, flush_all;

    issue_queue dut_i (.*);

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // reference model
    bit m_v[D], m_r1[D], m_r2[D];
    logic [5:0] m_op[D], m_dst[D], m_s1[D], m_s2[D], m_seq[D];
    logic [5:0] nseq = 0;
    bit e_v[IW];
    int e_i[IW];

    function automatic bit older(logic [5:0] a, logic [5:0] b);
        logic [5:0] d;
        d = b - a;
        return (d != 0) && !d[5];
    endfunction

    function automatic bit bc_hit(logic [5:0] t);
        for (int p = 0; p < BW; p++) if (bc_valid[p] && bc_tag[p] == t) return 1;
        return 0;
    endfunction

    function automatic int occupancy();
        int c = 0;
        for (int i = 0; i < D; i++) c += m_v[i];
        return c;
    endfunction

    task automatic chk(string lab, string sub, int port, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s/%s port %0d: actual %h expected %h at %0t", lab, sub, port, got, exp, $time);
        end
    endtask

    task automatic compute_exp();
        bit taken[D];
        for (int i = 0; i < D; i++) taken[i] = 0;
        for (int k = 0; k < IW; k++) begin
            e_v[k] = 0; e_i[k] = 0;
            for (int i = 0; i < D; i++) begin
                if (m_v[i] && m_r1[i] && m_r2[i] && !taken[i]) begin
                    if (!e_v[k] || older(m_seq[i], m_seq[e_i[k]])) begin
                        e_v[k] = 1; e_i[k] = i;
                    end
                end
            end
            if (e_v[k]) taken[e_i[k]] = 1;
        end
    endtask

    // called just after a negedge with inputs driven
    task automatic cycle(string lab);
        bit exp_rdy, nv[D];
        int slot;
        #1;
        compute_exp();
        exp_rdy = (occupancy() < D) && !flush_valid;
        chk(lab, "R2", -1, ins_ready, exp_rdy);
        for (int k = 0; k < IW; k++) begin
            chk(lab, "R7", k, iss_valid[k], e_v[k]);
            if (e_v[k] && iss_valid[k]) begin
                chk(lab, "R11", k, {iss_op[k], iss_dst[k], iss_src1[k], iss_src2[k]},
                    {m_op[e_i[k]], m_dst[e_i[k]], m_s1[e_i[k]], m_s2[e_i[k]]});
            end
        end
        // next model state
        slot = -1;
        for (int i = 0; i < D; i++) if (!m_v[i] && slot < 0) slot = i;
        for (int i = 0; i < D; i++) begin
            nv[i] = m_v[i];
            if (m_v[i]) begin
                if (bc_hit(m_s1[i])) m_r1[i] = 1;
                if (bc_hit(m_s2[i])) m_r2[i] = 1;
            end
        end
        for (int k = 0; k < IW; k++) if (e_v[k]) nv[e_i[k]] = 0;
        if (ins_valid && exp_rdy) begin
            nv[slot] = 1;
            m_op[slot] = ins_op; m_dst[slot] = ins_dst; m_seq[slot] = ins_seq;
            m_s1[slot] = ins_src1; m_r1[slot] = ins_src1_rdy | bc_hit(ins_src1);
            m_s2[slot] = ins_src2; m_r2[slot] = ins_src2_rdy | bc_hit(ins_src2);
            nseq = nseq + 1;
        end
        if (flush_valid) begin
            for (int i = 0; i < D; i++)
                if (flush_all || older(flush_seq, m_seq[i])) nv[i] = 0;
        end
        @(posedge clk);
        for (int i = 0; i < D; i++) m_v[i] = nv[i];
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        ins_valid = 0; ins_op = 0; ins_dst = 0; ins_src1 = 0; ins_src2 = 0;
        ins_src1_rdy = 0; ins_src2_rdy = 0; ins_seq = nseq;
        bc_valid = 0; bc_tag = '0;
        flush_valid = 0; flush_all = 0; flush_seq = 0;
    endtask

    task automatic put(logic [5:0] op, logic [5:0] dst, logic [5:0] s1, bit r1, logic [5:0] s2, bit r2);
        ins_valid = 1; ins_op = op; ins_dst = dst; ins_seq = nseq;
        ins_src1 = s1; ins_src1_rdy = r1; ins_src2 = s2; ins_src2_rdy = r2;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung, expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [5:0] keep_seq;
        void'($urandom(32'd4242));
        for (int i = 0; i < D; i++) m_v[i] = 0;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: empty after reset
        cycle("R1");

        // R2/R3: fill with waiting entries, then offer one more
        for (int n = 0; n < D; n++) begin
            idle_inputs(); put(6'(n + 1), 6'(n), 6'(32 + n), 0, 6'd1, 1);
            cycle("R3");
        end
        idle_inputs(); put(6'd63, 6'd63, 6'd0, 1, 6'd0, 1);
        cycle("R2");

        // R4: single broadcast wakes one entry
        idle_inputs(); bc_valid = 3'b100; bc_tag[2] = 6'd34;
        cycle("R4");
        idle_inputs(); cycle("R4");

        // R5: broadcast in the insert cycle
        idle_inputs(); put(6'd20, 6'd20, 6'd60, 0, 6'd61, 0);
        bc_valid = 3'b011; bc_tag[0] = 6'd60; bc_tag[1] = 6'd61;
        cycle("R5");
        idle_inputs(); cycle("R5");

        // R7/R8: many become ready at once; oldest first
        idle_inputs(); bc_valid = 3'b111; bc_tag[0] = 6'd32; bc_tag[1] = 6'd33; bc_tag[2] = 6'd39;
        cycle("R7");
        idle_inputs(); bc_valid = 3'b111; bc_tag[0] = 6'd35; bc_tag[1] = 6'd36; bc_tag[2] = 6'd38;
        cycle("R7");
        repeat (4) begin idle_inputs(); cycle("R8"); end
        idle_inputs(); bc_valid = 3'b001; bc_tag[0] = 6'd37; cycle("R8");
        repeat (2) begin idle_inputs(); cycle("R8"); end

        // R10: partial flush keeps the named entry and older ones
        keep_seq = 0;
        for (int n = 0; n < 6; n++) begin
            idle_inputs(); if (n == 2) keep_seq = nseq;
            put(6'(40 + n), 6'(40 + n), 6'd45, 0, 6'd2, 1);
            cycle("R10");
        end
        idle_inputs(); flush_valid = 1; flush_seq = keep_seq; cycle("R10");
        idle_inputs(); bc_valid = 3'b010; bc_tag[1] = 6'd45; cycle("R10");
        repeat (3) begin idle_inputs(); cycle("R10"); end

        // R9: flush everything
        for (int n = 0; n < 4; n++) begin
            idle_inputs(); put(6'(50 + n), 6'(50 + n), 6'd46, 0, 6'd3, 1); cycle("R9");
        end
        idle_inputs(); flush_valid = 1; flush_all = 1; flush_seq = nseq; cycle("R9");
        idle_inputs(); bc_valid = 3'b001; bc_tag[0] = 6'd46; cycle("R9");
        repeat (2) begin idle_inputs(); cycle("R9"); end

        // R6: random traffic
        for (int c = 0; c < 4000; c++) begin
            int span = 0;
            for (int i = 0; i < D; i++)
                if (m_v[i] && int'(6'(nseq - m_seq[i])) > span) span = int'(6'(nseq - m_seq[i]));
            idle_inputs();
            if (($urandom % 3) != 0 && span < 24)
                put(6'($urandom), 6'($urandom), 6'($urandom % 16), ($urandom % 2) == 1,
                    6'($urandom % 16), ($urandom % 2) == 1);
            for (int p = 0; p < BW; p++) begin
                bc_valid[p] = ($urandom % 5) < 3;
                bc_tag[p]   = 6'($urandom % 16);
            end
            if (($urandom % 64) == 0) begin
                flush_valid = 1; flush_all = ($urandom % 2) == 1;
                flush_seq = nseq - 6'($urandom % 8);
            end
            cycle("R6");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule